// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block is an on-chip scratchpad split into equal-width banks that serves one request from a group of lanes at a time. Each lane supplies an active flag, a word address, a write flag and write data. The arbiter works out which bank every word sits in. Lanes that land on different banks are all served in the same cycle. Lanes that land on different words of the same bank take turns over extra cycles.

Lanes that name the very same word share one bank access, which is a broadcast and costs nothing extra. When the request completes, the block raises a one-cycle completion strobe. At that point every reading lane's data is on its output, and a count of the service cycles spent is also available. This count is the conflict degree of the request.

Software that lays out arrays in the scratchpad uses the conflict degree to spot bad strides. A column walk over a row-major array whose row length equals the bank count piles every lane onto one bank. Adding one word of padding per row spreads the same walk across all banks.

Top module: `spad_conflict_arb`

## Requirements
- R1: A word address maps to bank `addr % BANKS` and to row `addr / BANKS` inside that bank, so consecutive word addresses fall in consecutive banks.
- R2: A request whose active lanes all use distinct banks completes with `done` high in the cycle after the accepting edge, and `conflict_degree` reads 1.
- R3: Lanes on one bank but on different words are served one after another: `conflict_degree` equals the largest number of distinct words that any single bank receives, and `done` rises that many cycles after the accepting edge.
- R4: A column read of a 32x32 row-major word array (lane r reads `r*32+c`) costs 32 cycles. The same read with one padding word per row (lane r reads `r*33+c`) costs 1 cycle.
- R5: Lanes that address the same word are served by a single bank access and add no cycle to the request.
- R6: When several lanes write the same word in one request, the data of the highest-numbered writing lane is what remains stored. A lane that reads that word in the same request gets the value held before the request.
- R7: A request is accepted on a clock edge where `req_valid` and `ready` are both high. `ready` stays low from the accepting edge until the cycle in which `done` is high. `req_valid` is ignored while `ready` is low and leaves the memory untouched.
- R8: `done` is a single-cycle pulse that coincides with `ready` returning high. In that cycle, each active reading lane's `rsp_rdata` slice holds its word, and the slices of inactive and writing lanes are zero. Outputs hold their values while idle.
- R9: A request with no active lane completes one cycle after acceptance with `conflict_degree` equal to 0.
- R10: After reset, `ready` is high, `done` is low, and `conflict_degree` and `rsp_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented |
| req_active | input | LANES | Per-lane participation flag |
| req_we | input | LANES | Per-lane write flag (1 = write, 0 = read) |
| req_addr | input | LANES*AW | Per-lane word address, lane l in bits `l*AW +: AW` |
| req_wdata | input | LANES*DW | Per-lane write data, lane l in bits `l*DW +: DW` |
| ready | output | 1 | Block can accept a request |
| done | output | 1 | Completion strobe of the current request |
| rsp_rdata | output | LANES*DW | Per-lane read data, lane l in bits `l*DW +: DW` |
| conflict_degree | output | DGW | Service cycles spent by the last request |

## Verification
The bench builds the block with its default parameters: 32 lanes, 32 banks of 64 rows and 32-bit words. At this size the full 32-way column conflict and its padded counterpart can be exercised directly. A sweep puts k distinct words on one bank for every k from 1 to 32, so every latency the block can produce is reached. A randomised phase then confines addresses to a 256-word window, which makes partial conflicts, broadcasts and same-word writes frequent. The expected degree, latency and data come from an arithmetic bank-count model and a shadow copy of memory.

// File: rtl/spad_pkg.sv
package spad_pkg;
   // Default geometry of the scratchpad
   localparam int DEF_LANES = 32;
   localparam int DEF_BANKS = 32;
   localparam int DEF_ROWS  = 64;
   localparam int DEF_DW    = 32;
endpackage

// File: rtl/spad_lane_split.sv
// Splits each lane's word address into bank index (low bits) and row (high bits).
module spad_lane_split #(
   parameter int LANES = 32,
   parameter int BW    = 5,
   parameter int RW    = 6,
   localparam int AW   = BW + RW
) (
   input  logic [LANES*AW-1:0] addr,
   output logic [LANES*BW-1:0] bank,
   output logic [LANES*RW-1:0] row
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign bank[l*BW +: BW] = addr[l*AW +: BW];
      assign row[l*RW +: RW]  = addr[l*AW + BW +: RW];
   end
endmodule

// File: rtl/spad_bank_pick.sv
// Per-bank selection: lowest pending lane leads; every pending lane on the
// same word joins it; highest writing lane in the group supplies data.
module spad_bank_pick #(
   parameter int LANES   = 32,
   parameter int BW      = 5,
   parameter int RW      = 6,
   parameter int BANK_ID = 0,
   localparam int LW     = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [LANES-1:0]    pend,
   input  logic [LANES*BW-1:0] lane_bank,
   input  logic [LANES*RW-1:0] lane_row,
   input  logic [LANES-1:0]    lane_we,
   output logic [LANES-1:0]    grant,
   output logic [RW-1:0]       acc_row,
   output logic                wr_en,
   output logic [LW-1:0]       wr_lane
);
   logic [LANES-1:0] hit;
   logic             found;

   always_comb begin
      found   = 1'b0;
      acc_row = '0;
      for (int l = 0; l < LANES; l++) begin
         hit[l] = pend[l] && (lane_bank[l*BW +: BW] == BW'(BANK_ID));
      end
      for (int l = 0; l < LANES; l++) begin
         if (hit[l] && !found) begin
            found   = 1'b1;
            acc_row = lane_row[l*RW +: RW];
         end
      end
      wr_en   = 1'b0;
      wr_lane = '0;
      for (int l = 0; l < LANES; l++) begin
         grant[l] = hit[l] && (lane_row[l*RW +: RW] == acc_row);
         if (grant[l] && lane_we[l]) begin
            wr_en   = 1'b1;
            wr_lane = LW'(l);
         end
      end
   end
endmodule

// File: rtl/spad_bank_store.sv
// One bank: asynchronous read, synchronous write to the same row.
module spad_bank_store #(
   parameter int ROWS = 64,
   parameter int DW   = 32,
   localparam int RW  = $clog2(ROWS)
) (
   input  logic          clk,
   input  logic [RW-1:0] row,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [ROWS];

   always_ff @(posedge clk) begin
      if (we) mem[row] <= wdata;
   end

   assign rdata = mem[row];
endmodule

// File: rtl/spad_conflict_arb.sv
module spad_conflict_arb #(
   parameter int LANES = spad_pkg::DEF_LANES,
   parameter int BANKS = spad_pkg::DEF_BANKS,
   parameter int ROWS  = spad_pkg::DEF_ROWS,
   parameter int DW    = spad_pkg::DEF_DW,
   localparam int BW   = $clog2(BANKS),
   localparam int RW   = $clog2(ROWS),
   localparam int AW   = BW + RW,
   localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1,
   localparam int DGW  = $clog2(LANES + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [LANES-1:0]    req_active,
   input  logic [LANES-1:0]    req_we,
   input  logic [LANES*AW-1:0] req_addr,
   input  logic [LANES*DW-1:0] req_wdata,
   output logic                ready,
   output logic                done,
   output logic [LANES*DW-1:0] rsp_rdata,
   output logic [DGW-1:0]      conflict_degree
);
   // Elaboration-time parameter checks
   if ((BANKS < 2) || ((BANKS & (BANKS - 1)) != 0)) begin : g_bad_banks
      $error("BANKS must be a power of two of at least 2");
   end
   if ((ROWS < 2) || ((ROWS & (ROWS - 1)) != 0)) begin : g_bad_rows
      $error("ROWS must be a power of two of at least 2");
   end
   if (LANES < 2) begin : g_bad_lanes
      $error("LANES must be at least 2");
   end

   // Latched request
   logic                busy_q;
   logic [LANES-1:0]    pend_q;
   logic [LANES-1:0]    we_q;
   logic [LANES*AW-1:0] addr_q;
   logic [LANES*DW-1:0] wdata_q;

   logic [LANES*BW-1:0] lane_bank;
   logic [LANES*RW-1:0] lane_row;

   spad_lane_split #(.LANES(LANES), .BW(BW), .RW(RW)) u_split (
      .addr (addr_q),
      .bank (lane_bank),
      .row  (lane_row)
   );

   logic [LANES-1:0] bank_grant [BANKS];
   logic [DW-1:0]    bank_rd    [BANKS];

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic [RW-1:0] acc_row;
      logic          wr_en;
      logic [LW-1:0] wr_lane;

      spad_bank_pick #(.LANES(LANES), .BW(BW), .RW(RW), .BANK_ID(b)) u_pick (
         .pend      (pend_q),
         .lane_bank (lane_bank),
         .lane_row  (lane_row),
         .lane_we   (we_q),
         .grant     (bank_grant[b]),
         .acc_row   (acc_row),
         .wr_en     (wr_en),
         .wr_lane   (wr_lane)
      );

      spad_bank_store #(.ROWS(ROWS), .DW(DW)) u_store (
         .clk   (clk),
         .row   (acc_row),
         .we    (busy_q && wr_en),
         .wdata (wdata_q[wr_lane*DW +: DW]),
         .rdata (bank_rd[b])
      );
   end

   logic [LANES-1:0] served;
   logic [LANES-1:0] pend_left;
   logic [DW-1:0]    lane_rd [LANES];

   always_comb begin
      served = '0;
      for (int b = 0; b < BANKS; b++) served = served | bank_grant[b];
   end
   assign pend_left = pend_q & ~served;

   for (genvar l = 0; l < LANES; l++) begin : g_rd
      assign lane_rd[l] = bank_rd[lane_bank[l*BW +: BW]];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q          <= 1'b0;
         done            <= 1'b0;
         pend_q          <= '0;
         we_q            <= '0;
         addr_q          <= '0;
         wdata_q         <= '0;
         rsp_rdata       <= '0;
         conflict_degree <= '0;
      end else begin
         done <= 1'b0;
         if (!busy_q && req_valid) begin
            busy_q          <= 1'b1;
            pend_q          <= req_active;
            we_q            <= req_we;
            addr_q          <= req_addr;
            wdata_q         <= req_wdata;
            rsp_rdata       <= '0;
            conflict_degree <= '0;
         end else if (busy_q) begin
            pend_q <= pend_left;
            if (|served) conflict_degree <= conflict_degree + 1'b1;
            for (int l = 0; l < LANES; l++) begin
               if (served[l] && !we_q[l]) rsp_rdata[l*DW +: DW] <= lane_rd[l];
            end
            if (pend_left == '0) begin
               busy_q <= 1'b0;
               done   <= 1'b1;
            end
         end
      end
   end

   assign ready = !busy_q;
endmodule

// File: rtl/spad_conflict_arb_chk.sv
module spad_conflict_arb_chk #(
   parameter int LANES = 32,
   parameter int DW    = 32,
   parameter int DGW   = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                ready,
   input logic                done,
   input logic [LANES*DW-1:0] rsp_rdata,
   input logic [DGW-1:0]      conflict_degree
);
   p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ready) |=> !ready);

   p_ready_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> done);

   p_done_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ready);

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !req_valid) |=> ($stable(rsp_rdata) && $stable(conflict_degree)));

   p_degree_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (int'(conflict_degree) <= LANES));
endmodule

bind spad_conflict_arb spad_conflict_arb_chk #(.LANES(LANES), .DW(DW), .DGW(DGW)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .req_valid       (req_valid),
   .ready           (ready),
   .done            (done),
   .rsp_rdata       (rsp_rdata),
   .conflict_degree (conflict_degree)
);

// File: tb/sim_spad_conflict_arb.sv
module sim_spad_conflict_arb;
   localparam int LANES = 32;
   localparam int BANKS = 32;
   localparam int ROWS  = 64;
   localparam int DW    = 32;
   localparam int AW    = $clog2(BANKS) + $clog2(ROWS);
   localparam int WORDS = BANKS * ROWS;
   localparam int DGW   = $clog2(LANES + 1);

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                req_valid = 1'b0;
   logic [LANES-1:0]    req_active = '0;
   logic [LANES-1:0]    req_we = '0;
   logic [LANES*AW-1:0] req_addr = '0;
   logic [LANES*DW-1:0] req_wdata = '0;
   logic                ready;
   logic                done;
   logic [LANES*DW-1:0] rsp_rdata;
   logic [DGW-1:0]      conflict_degree;

   always #4 clk = ~clk;

   spad_conflict_arb u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_active(req_active),
      .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
      .ready(ready), .done(done), .rsp_rdata(rsp_rdata),
      .conflict_degree(conflict_degree)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   logic [DW-1:0] model [WORDS];
   logic          b_act [LANES];
   logic          b_we  [LANES];
   int            b_addr [LANES];
   logic [DW-1:0] b_wd  [LANES];

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         finish_run();
      end
   end

   task automatic clear_req();
      for (int l = 0; l < LANES; l++) begin
         b_act[l] = 1'b0; b_we[l] = 1'b0; b_addr[l] = 0; b_wd[l] = '0;
      end
   endtask

   // Applies b_* as one request; checks degree, latency, ready and data.
   task automatic do_access(input string req, input bit stray);
      int cnt [BANKS];
      int deg, lat, cycles;
      logic [DW-1:0] exp_rd [LANES];
      bit first, rd_ok;
      int bad_lane;
      for (int b = 0; b < BANKS; b++) cnt[b] = 0;
      for (int l = 0; l < LANES; l++) begin
         first = b_act[l];
         for (int j = 0; j < l; j++)
            if (b_act[j] && b_act[l] && b_addr[j] == b_addr[l]) first = 1'b0;
         if (first) cnt[b_addr[l] % BANKS]++;
      end
      deg = 0;
      for (int b = 0; b < BANKS; b++) if (cnt[b] > deg) deg = cnt[b];
      lat = (deg == 0) ? 1 : deg;
      for (int l = 0; l < LANES; l++)
         exp_rd[l] = (b_act[l] && !b_we[l]) ? model[b_addr[l]] : '0;
      for (int l = 0; l < LANES; l++)
         if (b_act[l] && b_we[l]) model[b_addr[l]] = b_wd[l];

      @(negedge clk);
      for (int l = 0; l < LANES; l++) begin
         req_active[l]          = b_act[l];
         req_we[l]              = b_we[l];
         req_addr[l*AW +: AW]   = AW'(b_addr[l]);
         req_wdata[l*DW +: DW]  = b_wd[l];
      end
      req_valid = 1'b1;
      check(ready == 1'b1, "R7", "ready before accept", ready, 1);
      @(negedge clk);
      req_valid = 1'b0;
      if (stray) begin
         // R7: a request offered while busy must be ignored
         for (int l = 0; l < LANES; l++) begin
            req_active[l] = 1'b1; req_we[l] = 1'b1;
            req_addr[l*AW +: AW] = AW'(l);
            req_wdata[l*DW +: DW] = 32'hDEAD_0000 + DW'(l);
         end
         req_valid = 1'b1;
         check(ready == 1'b0, "R7", "ready low while busy", ready, 0);
      end
      cycles = 0;
      while (!done && cycles < 64) begin
         if (cycles > 0)
            check(ready == 1'b0, "R7", "ready low while serialising", ready, 0);
         @(negedge clk);
         req_valid = 1'b0;
         cycles++;
      end
      req_valid = 1'b0;
      check(cycles == lat, req, "cycles to done", cycles, lat);
      check(int'(conflict_degree) == deg, req, "conflict degree", conflict_degree, deg);
      check(ready == 1'b1, "R8", "ready with done", ready, 1);
      rd_ok = 1'b1; bad_lane = 0;
      for (int l = LANES - 1; l >= 0; l--)
         if (rsp_rdata[l*DW +: DW] !== exp_rd[l]) begin rd_ok = 1'b0; bad_lane = l; end
      check(rd_ok, req, $sformatf("read data lane %0d", bad_lane),
            rsp_rdata[bad_lane*DW +: DW], exp_rd[bad_lane]);
      @(negedge clk);
      check(done == 1'b0, "R8", "done is a pulse", done, 0);
   endtask

   initial begin
      clear_req();
      repeat (3) @(negedge clk);
      // R10: reset state
      check(ready == 1'b1, "R10", "ready in reset", ready, 1);
      check(done == 1'b0, "R10", "done in reset", done, 0);
      check(conflict_degree == '0, "R10", "degree in reset", conflict_degree, 0);
      check(rsp_rdata == '0, "R10", "rdata in reset", 0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(ready == 1'b1, "R10", "ready after reset", ready, 1);

      // Fill memory with consecutive addresses (R1, R2)
      for (int k = 0; k < WORDS / LANES; k++) begin
         clear_req();
         for (int l = 0; l < LANES; l++) begin
            b_act[l] = 1'b1; b_we[l] = 1'b1; b_addr[l] = k * LANES + l;
            b_wd[l] = DW'((k * LANES + l) * 32'h9E37 + 32'h1234);
         end
         do_access("R2", 1'b0);
      end

      // R1: consecutive reads, one per bank
      clear_req();
      for (int l = 0; l < LANES; l++) begin b_act[l] = 1'b1; b_addr[l] = 64 + l; end
      do_access("R1", 1'b0);

      // R4: column of row-major 32x32, then padded
      clear_req();
      for (int l = 0; l < LANES; l++) begin b_act[l] = 1'b1; b_addr[l] = l * 32 + 5; end
      do_access("R4", 1'b0);
      clear_req();
      for (int l = 0; l < LANES; l++) begin b_act[l] = 1'b1; b_addr[l] = l * 33 + 5; end
      do_access("R4", 1'b0);

      // R5: broadcast of one word, then two broadcast groups on one bank
      clear_req();
      for (int l = 0; l < LANES; l++) begin b_act[l] = 1'b1; b_addr[l] = 7; end
      do_access("R5", 1'b0);
      clear_req();
      for (int l = 0; l < LANES; l++) begin b_act[l] = 1'b1; b_addr[l] = (l < 16) ? 40 : 72; end
      do_access("R5", 1'b0);

      // R6: many writers on word 100, lane 3 reads it in the same request
      clear_req();
      for (int l = 0; l < LANES; l++) begin
         b_act[l] = 1'b1; b_we[l] = (l != 3); b_addr[l] = 100; b_wd[l] = 32'hA500 + DW'(l);
      end
      do_access("R6", 1'b0);
      clear_req();
      b_act[0] = 1'b1; b_addr[0] = 100;
      do_access("R6", 1'b0);

      // R9: no active lane
      clear_req();
      do_access("R9", 1'b0);

      // R7: stray request while busy, then read back the words it aimed at
      clear_req();
      for (int l = 0; l < 4; l++) begin b_act[l] = 1'b1; b_addr[l] = 200 + l * 32; end
      do_access("R7", 1'b1);
      clear_req();
      for (int l = 0; l < LANES; l++) begin b_act[l] = 1'b1; b_addr[l] = l; end
      do_access("R7", 1'b0);

      // R3: k distinct words on bank 3, for every k
      for (int k = 1; k <= LANES; k++) begin
         clear_req();
         for (int l = 0; l < LANES; l++) begin
            b_act[l] = 1'b1; b_addr[l] = (l % k) * BANKS + 3;
         end
         do_access("R3", 1'b0);
      end

      // R3 / R6: random mixes in a narrow window
      for (int t = 0; t < 300; t++) begin
         clear_req();
         for (int l = 0; l < LANES; l++) begin
            b_act[l]  = ($urandom_range(0, 3) != 0);
            b_we[l]   = ($urandom_range(0, 2) == 0);
            b_addr[l] = $urandom_range(0, 255);
            b_wd[l]   = $urandom;
         end
         do_access("R3", 1'b0);
      end

      finish_run();
   end
endmodule